// File: doc/BRIEF.md
# Predicated Vector Write-Back Unit

This block applies a governing predicate to a vector result on its way to the destination. It takes the freshly computed vector, the current contents of the destination, a predicate holding one bit per data byte, an element-size code and a mode code, and produces either a destination vector or a set of per-byte write strobes with store data. One datapath covers register write-back with merging, register write-back with zeroing, load returns and predicated stores.

An element counts as active when the predicate bit that belongs to its lowest-addressed byte is set. The other predicate bits inside a wider element have no effect. The vector width is a parameter. The result is registered and comes out one cycle after a valid input, and it holds its value while no new input arrives.

Top module: `pred_wb_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is low.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low the output vector and strobes keep their last values.
- R3: Element size code 0/1/2/3 selects 1/2/4/8-byte elements. Byte b belongs to the element that starts at byte b rounded down to a multiple of the element size. The element is active if and only if `pred` has the bit of that start byte set. The other predicate bits of the element are ignored.
- R4: Mode code 0 (merge): bytes of active elements take `new_vec`, and bytes of inactive elements take `old_vec`. `out_strb` is all zero.
- R5: Mode code 1 (zero): bytes of active elements take `new_vec`, and bytes of inactive elements are zero. `out_strb` is all zero.
- R6: Mode code 2 (store): `out_strb` is set for every byte of an active element and clear for every byte of an inactive one. The data byte is `new_vec` where the strobe is set and zero elsewhere. `old_vec` has no effect.
- R7: Mode code 3 (load return) gives the same result as mode 1, so inactive load bytes read as zero and never as `old_vec` contents.
- R8: An all-ones predicate gives `out_vec` equal to `new_vec` in every mode, and all strobes set in store mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input operands are valid this cycle |
| mode | input | 2 | 0 merge, 1 zero, 2 store, 3 load return |
| esize | input | 2 | Element size code: 0 byte, 1 half, 2 word, 3 double |
| pred | input | VL_BITS/8 | Governing predicate, one bit per byte |
| new_vec | input | VL_BITS | Newly computed or loaded vector |
| old_vec | input | VL_BITS | Previous destination contents |
| out_valid | output | 1 | Registered result is valid |
| out_vec | output | VL_BITS | Destination vector or store data |
| out_strb | output | VL_BITS/8 | Per-byte store write strobes |

## Verification
The clocked assertions assume that `in_valid` is low while reset is asserted and that `mode`, `esize`, `pred` and both vectors are known whenever `in_valid` is high. The bench holds `in_valid` low through reset and drives every operand on the falling edge before it raises `in_valid`. Random predicates are drawn over the full byte width, so the bits that an element ignores carry random values and R3 is tested. Directed cases add predicates where only a non-lowest bit is set, all-zero and all-ones predicates, and idle cycles with changed inputs.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    WB_MERGE = 2'd0,
    WB_ZERO  = 2'd1,
    WB_STORE = 2'd2,
    WB_LOAD  = 2'd3
  } wb_mode_e;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esize_e;
endpackage

// File: rtl/pwb_act_expand.sv
// Expands the governing predicate to a per-byte activity mask: every byte
// copies the predicate bit of the first byte of its element.
module pwb_act_expand
  import pwb_pkg::*;
#(
  parameter int NBYTES = 32
) (
  input  logic [NBYTES-1:0] pred,
  input  logic [1:0]        esize,
  output logic [NBYTES-1:0] act_byte
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int BH = b - (b % 2);
    localparam int BW = b - (b % 4);
    localparam int BD = b - (b % 8);
    always_comb begin
      case (esize_e'(esize))
        ESZ_B:   act_byte[b] = pred[b];
        ESZ_H:   act_byte[b] = pred[BH];
        ESZ_W:   act_byte[b] = pred[BW];
        default: act_byte[b] = pred[BD];
      endcase
    end
  end

  // Bytes of one double-size element must agree (R3)
  always_comb begin
    if (esize == ESZ_D) begin
      for (int k = 0; k < NBYTES; k++) begin
        assert_elem_uniform_R3: assert (act_byte[k] == act_byte[k - (k % 8)]);
      end
    end
  end

endmodule

// File: rtl/pwb_byte_mux.sv
// Per-byte selection of result data and store strobe.
module pwb_byte_mux
  import pwb_pkg::*;
#(
  parameter int NBYTES = 32
) (
  input  logic [1:0]          mode,
  input  logic [NBYTES-1:0]   act_byte,
  input  logic [NBYTES*8-1:0] new_vec,
  input  logic [NBYTES*8-1:0] old_vec,
  output logic [NBYTES*8-1:0] vec_nxt,
  output logic [NBYTES-1:0]   strb_nxt
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_comb begin
      strb_nxt[b] = 1'b0;
      if (act_byte[b]) begin
        vec_nxt[b*8 +: 8] = new_vec[b*8 +: 8];
      end else if (wb_mode_e'(mode) == WB_MERGE) begin
        vec_nxt[b*8 +: 8] = old_vec[b*8 +: 8];
      end else begin
        vec_nxt[b*8 +: 8] = 8'h00;
      end
      if (wb_mode_e'(mode) == WB_STORE) begin
        strb_nxt[b] = act_byte[b];
      end
    end
  end

endmodule

// File: rtl/pred_wb_unit.sv
module pred_wb_unit
  import pwb_pkg::*;
#(
  parameter int VL_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           mode,
  input  logic [1:0]           esize,
  input  logic [VL_BITS/8-1:0] pred,
  input  logic [VL_BITS-1:0]   new_vec,
  input  logic [VL_BITS-1:0]   old_vec,
  output logic                 out_valid,
  output logic [VL_BITS-1:0]   out_vec,
  output logic [VL_BITS/8-1:0] out_strb
);

  localparam int NBYTES = VL_BITS / 8;

  logic [NBYTES-1:0]  act_byte;
  logic [VL_BITS-1:0] act_bits;
  logic [VL_BITS-1:0] vec_nxt;
  logic [NBYTES-1:0]  strb_nxt;
  logic               valid_nxt;
  logic               data_en;

  pwb_act_expand #(.NBYTES(NBYTES)) u_expand (
    .pred     (pred),
    .esize    (esize),
    .act_byte (act_byte)
  );

  pwb_byte_mux #(.NBYTES(NBYTES)) u_mux (
    .mode     (mode),
    .act_byte (act_byte),
    .new_vec  (new_vec),
    .old_vec  (old_vec),
    .vec_nxt  (vec_nxt),
    .strb_nxt (strb_nxt)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_bits
    assign act_bits[b*8 +: 8] = {8{act_byte[b]}};
  end

  always_comb begin
    valid_nxt = in_valid;
    data_en   = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      out_vec  <= vec_nxt;
      out_strb <= strb_nxt;
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_vec) && $stable(out_strb)));

  assert_merge_keeps_old_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == WB_MERGE) |=>
      ((out_vec & ~$past(act_bits)) == ($past(old_vec) & ~$past(act_bits))));

  assert_zero_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == WB_ZERO || mode == WB_LOAD)) |=>
      ((out_vec & ~$past(act_bits)) == '0));

  assert_regmode_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != WB_STORE) |=> (out_strb == '0));

  assert_store_byte0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == WB_STORE) |=> (out_strb[0] == $past(pred[0])));

  assert_alltrue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&pred)) |=>
      (out_vec == $past(new_vec)) &&
      ($past(mode) != WB_STORE || (&out_strb)));

endmodule

// File: tb/pred_wb_unit_bench.sv
module pred_wb_unit_bench;
  localparam int VW = 256;
  localparam int NB = VW / 8;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    mode;
  logic [1:0]    esize;
  logic [NB-1:0] pred;
  logic [VW-1:0] new_vec;
  logic [VW-1:0] old_vec;
  logic          out_valid;
  logic [VW-1:0] out_vec;
  logic [NB-1:0] out_strb;

  int checks;
  int failures;
  bit done;

  logic [VW-1:0] last_vec;
  logic [NB-1:0] last_strb;

  pred_wb_unit #(.VL_BITS(VW)) u_pred_wb_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .esize     (esize),
    .pred      (pred),
    .new_vec   (new_vec),
    .old_vec   (old_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .out_strb  (out_strb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [VW-1:0] rvec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Expected result from the requirements (R3..R8)
  function automatic void model(input logic [1:0] md, input logic [1:0] es,
                                input logic [NB-1:0] p, input logic [VW-1:0] nv,
                                input logic [VW-1:0] ov, output logic [VW-1:0] ev,
                                output logic [NB-1:0] estrb);
    for (int b = 0; b < NB; b++) begin
      int eb;
      int base;
      bit a;
      eb   = 1 << es;
      base = b - (b % eb);
      a    = p[base];
      estrb[b] = (md == 2'd2) ? a : 1'b0;
      if (a)              ev[b*8 +: 8] = nv[b*8 +: 8];
      else if (md == 2'd0) ev[b*8 +: 8] = ov[b*8 +: 8];
      else                ev[b*8 +: 8] = 8'h00;
    end
  endfunction

  task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s vec actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_strb(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s strb actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive one operation at a falling edge and check one cycle later
  task automatic run(input string req, input logic [1:0] md, input logic [1:0] es,
                     input logic [NB-1:0] p, input logic [VW-1:0] nv, input logic [VW-1:0] ov);
    logic [VW-1:0] ev;
    logic [NB-1:0] estrb;
    @(negedge clk);
    in_valid = 1'b1;
    mode     = md;
    esize    = es;
    pred     = p;
    new_vec  = nv;
    old_vec  = ov;
    model(md, es, p, nv, ov, ev, estrb);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit(req, out_valid, 1'b1);
    check_vec(req, out_vec, ev);
    check_strb(req, out_strb, estrb);
    last_vec  = ev;
    last_strb = estrb;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a;
    logic [VW-1:0] o;
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    mode     = 2'd0;
    esize    = 2'd0;
    pred     = '0;
    new_vec  = '0;
    old_vec  = '0;
    repeat (3) @(negedge clk);
    check_bit("R1 reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 after release", out_valid, 1'b0);

    a = rvec();
    o = rvec();
    // R4: all-false predicate keeps the old vector
    run("R4 merge none", 2'd0, 2'd0, '0, a, o);
    // R5: all-false predicate clears everything
    run("R5 zero none", 2'd1, 2'd2, '0, a, o);
    // R8: all-true predicate in each mode
    run("R8 merge all", 2'd0, 2'd3, '1, a, o);
    run("R8 zero all", 2'd1, 2'd1, '1, a, o);
    run("R8 store all", 2'd2, 2'd0, '1, a, o);
    // R3: only non-lowest bits of each double element set, ignored
    run("R3 ignored bits", 2'd2, 2'd3, {NB/8{8'hFE}}, a, o);
    run("R3 lowest bit only", 2'd0, 2'd3, {NB/8{8'h01}}, a, o);
    run("R3 word elements", 2'd1, 2'd2, {NB/4{4'b0110}}, a, o);
    run("R3 half elements", 2'd2, 2'd1, {NB/2{2'b01}}, a, o);
    // R7: load return zeroes inactive lanes
    run("R7 load", 2'd3, 2'd0, {NB/2{2'b10}}, a, o);
    // R6: old_vec has no effect on a store
    run("R6 store old A", 2'd2, 2'd2, {NB/4{4'h5}}, a, '0);
    run("R6 store old B", 2'd2, 2'd2, {NB/4{4'h5}}, a, '1);

    // R2: idle cycle with changed inputs leaves outputs alone
    @(negedge clk);
    mode    = 2'd0;
    pred    = '1;
    new_vec = rvec();
    old_vec = rvec();
    @(negedge clk);
    check_bit("R2 idle valid", out_valid, 1'b0);
    check_vec("R2 idle hold", out_vec, last_vec);
    check_strb("R2 idle hold", out_strb, last_strb);

    // Random mix over modes, sizes and predicates (R3 R4 R5 R6 R7)
    for (int n = 0; n < 300; n++) begin
      logic [NB-1:0] p;
      p = '0;
      for (int k = 0; k < NB; k += 32) p[k +: 32] = $urandom;
      run("R3/R4/R5/R6/R7 random", 2'($urandom_range(3, 0)), 2'($urandom_range(3, 0)),
          p, rvec(), rvec());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule